// File: doc/BRIEF.md
# Chained DMA Descriptor Walker

The walker is the control half of a DMA channel. Software builds a list of four-word descriptors in memory and hands each one to the engine by setting an ownership flag. The walker fetches them one at a time through a simple word read/write port. For each descriptor it owns, it passes the buffer address and byte count to an external data mover. When the mover is done, the walker writes the status word back with ownership returned to software. It then moves to the next descriptor.

The next descriptor comes from the link word when the descriptor is marked as chained, and from the following 16-byte slot when it is not. A ring is closed by pointing the last link back at the head. When the walker reaches a descriptor it does not own, it stops and raises a buffer-unavailable flag. It waits there until software issues a poll demand or drops the run enable.

Each descriptor is laid out as four words, at byte offsets 0, 4, 8 and 12 from the descriptor address:

| Word | Offset | Contents |
|------|--------|----------|
| status | +0 | bit 31 is ownership (1 means the engine owns it) |
| control | +4 | bits 10:0 are the byte length; bit 24 selects chaining; bit 29 marks the first segment; bit 30 marks the last segment; bit 31 requests an interrupt on completion |
| buffer | +8 | buffer address |
| link | +12 | next descriptor address |

Top module: `desc_walker`

## Requirements
- R1: While reset is held and in the cycle after it is released, mem_req, mv_req, irq_done and buf_unavail are 0, and cur_desc_addr and cur_buf_addr are 0.
- R2: When run_en is seen high while the walker is idle, it loads base_addr as the current descriptor address. One cycle later it issues a read of the status word at that address.
- R3: A status word with bit 31 equal to 0 is not owned by the engine. Reading one sets buf_unavail and suspends the walker. While suspended, no further memory or mover requests are made, and cur_desc_addr still points at that descriptor.
- R4: For an owned descriptor, the walker raises mv_req with the following fields, and holds them until mv_done:
  - mv_addr, taken from the buffer word;
  - mv_len, taken from control bits 10:0;
  - mv_first, taken from control bit 29;
  - mv_last, taken from control bit 30.
- R5: After the mover finishes, the walker writes the status word back with bit 31 cleared and all other bits unchanged.
- R6: If control bit 31 is set, irq_done pulses high for exactly one cycle, in the cycle after the write-back is acknowledged. If the bit is clear, irq_done stays low.
- R7: If control bit 24 is set, the next descriptor address is the link word. If it is clear, the next address is the current address plus 16.
- R8: A chained ring whose last link points back at the head is walked again from the head.
- R9: A one-cycle poll_req pulse while suspended clears buf_unavail in the next cycle and refetches the same descriptor. poll_req has no effect in any other state.
- R10: If run_en is cleared while a descriptor is in progress, the walker completes that descriptor, including its write-back. It then goes idle without fetching the next descriptor.
- R11: A descriptor whose length is 0 is written back without any mover request.
- R12: cur_buf_addr shows the buffer word of the descriptor being processed. cur_desc_addr shows the descriptor address the walker is working on, or will fetch next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable level |
| poll_req | input | 1 | Poll-demand strobe, resumes a suspended walk |
| base_addr | input | AW | List head address, taken when starting from idle |
| mem_req | output | 1 | Memory word access request, held until mem_ack |
| mem_we | output | 1 | 1 for the status write-back, 0 for reads |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access done; read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Data-mover request, held until mv_done |
| mv_addr | output | 32 | Buffer address |
| mv_len | output | LEN_W | Buffer length in bytes |
| mv_first | output | 1 | First-segment flag |
| mv_last | output | 1 | Last-segment flag |
| mv_done | input | 1 | Mover finished the buffer |
| irq_done | output | 1 | One-cycle completion interrupt |
| buf_unavail | output | 1 | Set on meeting a descriptor the engine does not own |
| cur_desc_addr | output | AW | Current descriptor address |
| cur_buf_addr | output | 32 | Current buffer address |

## Verification
Each memory word costs two cycles with the one-cycle acknowledging memory model: the request appears, the acknowledge follows one edge later, and the state advances on the edge after that. A full descriptor therefore takes about ten cycles plus the mover handshake. irq_done appears one cycle after the write-back acknowledge. A poll clears buf_unavail one cycle after it is sampled, and the first read after a start is visible one cycle after run_en is seen. The bench samples on falling edges and polls for level results with bounded waits. It checks single-cycle results at exactly the cycle they are due. It counts mover transfers, interrupts and reads at the rising edge, so that effects which are absent can be shown at the ports.

// File: rtl/dw_pkg.sv
package dw_pkg;
    localparam int WORD_W         = 32;
    localparam int WORDS_PER_DESC = 4;
    localparam int IDX_W          = $clog2(WORDS_PER_DESC);
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int DESC_STRIDE    = WORDS_PER_DESC * BYTES_PER_WORD;

    localparam int LEN_W     = 11;
    localparam int OWN_BIT   = 31;
    localparam int CHAIN_BIT = 24;
    localparam int FIRST_BIT = 29;
    localparam int LAST_BIT  = 30;
    localparam int IRQ_BIT   = 31;

    localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_CTL  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_BUF  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_LINK = IDX_W'(3);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MOVE,
        ST_WBACK,
        ST_SUSP
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] buf_addr;
        logic [WORD_W-1:0] link;
        logic [LEN_W-1:0]  len;
        logic              first;
        logic              last;
        logic              irq;
        logic              chain;
    } desc_t;

    function automatic logic [WORD_W-1:0] release_own(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[OWN_BIT] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/dw_desc_store.sv
module dw_desc_store
    import dw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_en,
    input  logic [IDX_W-1:0]     cap_idx,
    input  logic [WORD_W-1:0]    cap_data,
    output desc_t                desc
);
    logic [WORD_W-1:0] word_q [WORDS_PER_DESC];
    logic [LEN_W-1:0]  len_q;
    logic              first_q, last_q, irq_q, chain_q;

    for (genvar i = 0; i < WORDS_PER_DESC; i++) begin : g_word
        if (i == int'(IDX_CTL)) begin : g_ctl
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q[i] <= '0;
                    len_q     <= '0;
                    first_q   <= 1'b0;
                    last_q    <= 1'b0;
                    irq_q     <= 1'b0;
                    chain_q   <= 1'b0;
                end else if (cap_en && cap_idx == IDX_W'(i)) begin
                    word_q[i] <= '0;
                    len_q     <= cap_data[LEN_W-1:0];
                    first_q   <= cap_data[FIRST_BIT];
                    last_q    <= cap_data[LAST_BIT];
                    irq_q     <= cap_data[IRQ_BIT];
                    chain_q   <= cap_data[CHAIN_BIT];
                end
            end
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (rst)
                    word_q[i] <= '0;
                else if (cap_en && cap_idx == IDX_W'(i))
                    word_q[i] <= cap_data;
            end
        end
    end

    always_comb begin
        desc          = '0;
        desc.stat     = word_q[IDX_STAT];
        desc.buf_addr = word_q[IDX_BUF];
        desc.link     = word_q[IDX_LINK];
        desc.len      = len_q;
        desc.first    = first_q;
        desc.last     = last_q;
        desc.irq      = irq_q;
        desc.chain    = chain_q;
    end
endmodule

// File: rtl/dw_ctrl.sv
module dw_ctrl
    import dw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              poll_req,
    input  logic [AW-1:0]     base_addr,
    input  logic              mem_ack,
    input  logic              rd_own,
    input  logic              mv_done,
    input  logic              len_zero,
    input  logic              chain,
    input  logic              irq_en,
    input  logic [WORD_W-1:0] link,
    output walk_state_t       state,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic [AW-1:0]     cur_addr,
    output logic              irq_pulse,
    output logic              bua_flag
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS_PER_DESC - 1);

    logic [AW-1:0] next_addr;

    always_comb begin
        if (chain)
            next_addr = link[AW-1:0];
        else
            next_addr = cur_addr + AW'(DESC_STRIDE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            fetch_idx <= '0;
            cur_addr  <= '0;
            irq_pulse <= 1'b0;
            bua_flag  <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (run_en) begin
                        cur_addr  <= base_addr;
                        fetch_idx <= '0;
                        bua_flag  <= 1'b0;
                        state     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (fetch_idx == IDX_STAT && !rd_own) begin
                            bua_flag <= 1'b1;
                            state    <= ST_SUSP;
                        end else if (fetch_idx == LAST_IDX) begin
                            fetch_idx <= '0;
                            state     <= len_zero ? ST_WBACK : ST_MOVE;
                        end else begin
                            fetch_idx <= fetch_idx + 1'b1;
                        end
                    end
                end
                ST_MOVE: begin
                    if (mv_done)
                        state <= ST_WBACK;
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        irq_pulse <= irq_en;
                        cur_addr  <= next_addr;
                        state     <= run_en ? ST_FETCH : ST_IDLE;
                    end
                end
                ST_SUSP: begin
                    if (!run_en) begin
                        state <= ST_IDLE;
                    end else if (poll_req) begin
                        bua_flag  <= 1'b0;
                        fetch_idx <= '0;
                        state     <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dw_port.sv
module dw_port
    import dw_pkg::*;
#(
    parameter int AW = 32
) (
    input  walk_state_t       state,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic [AW-1:0]     cur_addr,
    input  logic [WORD_W-1:0] stat_word,
    input  logic [WORD_W-1:0] buf_word,
    input  logic [LEN_W-1:0]  len,
    input  logic              first,
    input  logic              last,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mv_req,
    output logic [WORD_W-1:0] mv_addr,
    output logic [LEN_W-1:0]  mv_len,
    output logic              mv_first,
    output logic              mv_last
);
    localparam int OFS_W = IDX_W + $clog2(BYTES_PER_WORD);

    logic [OFS_W-1:0] word_ofs;

    assign word_ofs = OFS_W'(fetch_idx) * OFS_W'(BYTES_PER_WORD);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_addr;
        mem_wdata = '0;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + AW'(word_ofs);
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = release_own(stat_word);
            end
            default: ;
        endcase
    end

    always_comb begin
        mv_req   = (state == ST_MOVE);
        mv_addr  = mv_req ? buf_word : '0;
        mv_len   = mv_req ? len : '0;
        mv_first = mv_req & first;
        mv_last  = mv_req & last;
    end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
    import dw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              poll_req,
    input  logic [AW-1:0]     base_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mv_req,
    output logic [WORD_W-1:0] mv_addr,
    output logic [LEN_W-1:0]  mv_len,
    output logic              mv_first,
    output logic              mv_last,
    input  logic              mv_done,
    output logic              irq_done,
    output logic              buf_unavail,
    output logic [AW-1:0]     cur_desc_addr,
    output logic [WORD_W-1:0] cur_buf_addr
);
    walk_state_t      state;
    logic [IDX_W-1:0] fetch_idx;
    desc_t            desc;
    logic             cap_en;

    assign cap_en = (state == ST_FETCH) && mem_ack;

    dw_desc_store u_store (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_idx  (fetch_idx),
        .cap_data (mem_rdata),
        .desc     (desc)
    );

    dw_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .poll_req  (poll_req),
        .base_addr (base_addr),
        .mem_ack   (mem_ack),
        .rd_own    (mem_rdata[OWN_BIT]),
        .mv_done   (mv_done),
        .len_zero  (desc.len == '0),
        .chain     (desc.chain),
        .irq_en    (desc.irq),
        .link      (desc.link),
        .state     (state),
        .fetch_idx (fetch_idx),
        .cur_addr  (cur_desc_addr),
        .irq_pulse (irq_done),
        .bua_flag  (buf_unavail)
    );

    dw_port #(.AW(AW)) u_port (
        .state     (state),
        .fetch_idx (fetch_idx),
        .cur_addr  (cur_desc_addr),
        .stat_word (desc.stat),
        .buf_word  (desc.buf_addr),
        .len       (desc.len),
        .first     (desc.first),
        .last      (desc.last),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mv_req    (mv_req),
        .mv_addr   (mv_addr),
        .mv_len    (mv_len),
        .mv_first  (mv_first),
        .mv_last   (mv_last)
    );

    assign cur_buf_addr = desc.buf_addr;
endmodule

// File: rtl/dw_checker.sv
module dw_checker
    import dw_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_wdata_own,
    input logic              mem_ack,
    input logic              mv_req,
    input logic [WORD_W-1:0] mv_addr,
    input logic [LEN_W-1:0]  mv_len,
    input logic              mv_done,
    input logic              irq_done,
    input logic              buf_unavail
);
    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2
    AST_MV_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mv_req && !mv_done) |=> (mv_req && $stable(mv_addr) && $stable(mv_len))); // R4
    AST_WB_RELEASES_OWN: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata_own); // R5
    AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> $past(mem_req && mem_we && mem_ack)); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_done |=> !irq_done); // R6
    AST_NO_ZERO_MOVE: assert property (@(posedge clk) disable iff (rst)
        mv_req |-> (mv_len != '0)); // R11
    AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        buf_unavail |-> (!mem_req && !mv_req)); // R3
endmodule

bind desc_walker dw_checker #(.AW(AW)) u_dw_checker (
    .clk           (clk),
    .rst           (rst),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata_own (mem_wdata[dw_pkg::OWN_BIT]),
    .mem_ack       (mem_ack),
    .mv_req        (mv_req),
    .mv_addr       (mv_addr),
    .mv_len        (mv_len),
    .mv_done       (mv_done),
    .irq_done      (irq_done),
    .buf_unavail   (buf_unavail)
);

// File: tb/tb_desc_walker.sv
`timescale 1ns/1ps
module tb_desc_walker;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        poll_req = 1'b0;
    logic [31:0] base_addr = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mv_req, mv_first, mv_last, mv_done;
    logic [31:0] mv_addr;
    logic [10:0] mv_len;
    logic        irq_done, buf_unavail;
    logic [31:0] cur_desc_addr, cur_buf_addr;

    always #5 clk = ~clk;

    desc_walker #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .run_en(run_en), .poll_req(poll_req),
        .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mv_req(mv_req), .mv_addr(mv_addr),
        .mv_len(mv_len), .mv_first(mv_first), .mv_last(mv_last),
        .mv_done(mv_done), .irq_done(irq_done), .buf_unavail(buf_unavail),
        .cur_desc_addr(cur_desc_addr), .cur_buf_addr(cur_buf_addr)
    );

    // memory model: one-cycle acknowledge, 64 words
    logic [31:0] mem [64];
    logic        tb_wr = 1'b0;
    logic [5:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;
    int          mv_cnt, irq_cnt, rd_cnt;
    logic [31:0] log_addr [8];
    logic [10:0] log_len [8];
    logic        log_first [8];
    logic        log_last [8];

    always_ff @(posedge clk) begin
        if (tb_wr) mem[tb_wa] <= tb_wd;
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            mem_rdata <= mem[mem_addr[7:2]];
            if (mem_req && !mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mv_done <= 1'b0;
            mv_cnt <= 0; irq_cnt <= 0; rd_cnt <= 0;
        end else begin
            mv_done <= mv_req && !mv_done;
            if (mv_req && mv_done) begin
                log_addr[mv_cnt[2:0]] <= mv_addr;
                log_len[mv_cnt[2:0]] <= mv_len;
                log_first[mv_cnt[2:0]] <= mv_first;
                log_last[mv_cnt[2:0]] <= mv_last;
                mv_cnt <= mv_cnt + 1;
            end
            if (irq_done) irq_cnt <= irq_cnt + 1;
            if (mem_req && mem_ack && !mem_we) rd_cnt <= rd_cnt + 1;
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        tb_wr = 1'b1; tb_wa = addr[7:2]; tb_wd = data;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0,
                            input logic [31:0] w1, input logic [31:0] w2,
                            input logic [31:0] w3);
        put(a, w0); put(a + 4, w1); put(a + 8, w2); put(a + 12, w3);
    endtask

    task automatic wait_bua(input string req);
        int n = 0;
        while (!buf_unavail && n < 2000) begin @(negedge clk); n++; end
        chk(buf_unavail, req, "buf_unavail reached", {31'd0, buf_unavail}, 32'd1);
    endtask

    task automatic go_idle();
        @(negedge clk); run_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !mv_req && !irq_done && !buf_unavail, "R1", "idle outputs",
            {28'd0, mem_req, mv_req, irq_done, buf_unavail}, 32'd0);
        chk(cur_desc_addr == 0 && cur_buf_addr == 0, "R1", "status zero",
            cur_desc_addr | cur_buf_addr, 32'd0);
    endtask

    task automatic t_ring();
        int n = 0;
        int rd_snap;
        put_desc(32'h00, 32'h8000_0055, 32'hA100_0064, 32'h1000, 32'h40);
        put_desc(32'h40, 32'h8000_0000, 32'h4100_0008, 32'h2000, 32'h00);
        base_addr = 32'h0;
        @(negedge clk); run_en = 1'b1;
        while (!mv_req && n < 500) begin @(negedge clk); n++; end
        chk(cur_buf_addr == 32'h1000, "R12", "cur_buf_addr in move", cur_buf_addr, 32'h1000);
        chk(mv_addr == 32'h1000 && mv_len == 11'd100, "R4", "mover fields",
            mv_addr + 32'(mv_len), 32'h1064);
        wait_bua("R8");
        chk(mv_cnt == 2, "R4", "mover count", mv_cnt, 2);
        chk(log_first[0] && !log_last[0] && !log_first[1] && log_last[1], "R4",
            "first/last flags", {28'd0, log_first[0], log_last[0], log_first[1], log_last[1]},
            32'b1001);
        chk(log_addr[1] == 32'h2000 && log_len[1] == 11'd8, "R4", "second buffer",
            log_addr[1], 32'h2000);
        chk(mem[0] == 32'h55, "R5", "status write-back", mem[0], 32'h55);
        chk(mem[16] == 32'h0, "R5", "second write-back", mem[16], 32'h0);
        chk(irq_cnt == 1, "R6", "irq count", irq_cnt, 1);
        chk(cur_desc_addr == 32'h0, "R8", "wrapped to head", cur_desc_addr, 32'h0);
        rd_snap = rd_cnt;
        repeat (20) @(negedge clk);
        chk(rd_cnt == rd_snap && buf_unavail, "R3", "suspended is quiet", rd_cnt, rd_snap);
        chk(cur_desc_addr == 32'h0, "R3", "pointer held", cur_desc_addr, 32'h0);
    endtask

    task automatic t_poll();
        put(32'h00, 32'h8000_0077);
        @(negedge clk); poll_req = 1'b1;
        @(negedge clk); poll_req = 1'b0;
        chk(!buf_unavail, "R9", "flag cleared by poll", {31'd0, buf_unavail}, 32'd0);
        wait_bua("R9");
        chk(mv_cnt == 3 && log_addr[2] == 32'h1000, "R9", "refetched head", mv_cnt, 3);
        chk(cur_desc_addr == 32'h40, "R7", "chained link followed", cur_desc_addr, 32'h40);
        chk(mem[0] == 32'h77, "R5", "write-back after poll", mem[0], 32'h77);
    endtask

    task automatic t_zero_seq();
        int irq_snap = irq_cnt;
        int mv_snap = mv_cnt;
        go_idle();
        put_desc(32'h80, 32'h8000_0003, 32'h8000_0000, 32'h3000, 32'hDEAD_BEE0);
        put(32'h90, 32'h0);
        base_addr = 32'h80;
        @(negedge clk); run_en = 1'b1;
        @(negedge clk);
        chk(mem_req && !mem_we && mem_addr == 32'h80, "R2", "first read at base",
            mem_addr, 32'h80);
        wait_bua("R11");
        chk(mv_cnt == mv_snap, "R11", "no mover request", mv_cnt, mv_snap);
        chk(irq_cnt == irq_snap + 1, "R6", "irq on zero length", irq_cnt, irq_snap + 1);
        chk(mem[32] == 32'h3, "R11", "zero length written back", mem[32], 32'h3);
        chk(cur_desc_addr == 32'h90, "R7", "sequential next", cur_desc_addr, 32'h90);
    endtask

    task automatic t_stop();
        int n = 0;
        int mv_snap = mv_cnt;
        go_idle();
        put_desc(32'hC0, 32'h8000_0000, 32'h0100_0010, 32'h4000, 32'hD0);
        put_desc(32'hD0, 32'h8000_0000, 32'h0100_0020, 32'h5000, 32'hC0);
        base_addr = 32'hC0;
        @(negedge clk); run_en = 1'b1;
        while (!mv_req && n < 500) begin @(negedge clk); n++; end
        run_en = 1'b0;
        repeat (40) @(negedge clk);
        chk(mem[48] == 32'h0, "R10", "current descriptor completed", mem[48], 32'h0);
        chk(mem[52] == 32'h8000_0000, "R10", "next not touched", mem[52], 32'h8000_0000);
        chk(mv_cnt == mv_snap + 1, "R10", "one transfer", mv_cnt, mv_snap + 1);
        chk(!mem_req && !buf_unavail, "R10", "idle after stop",
            {30'd0, mem_req, buf_unavail}, 32'd0);
        chk(cur_desc_addr == 32'hD0, "R12", "pointer at next", cur_desc_addr, 32'hD0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        t_reset();
        t_ring();
        t_poll();
        t_zero_seq();
        t_stop();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end
endmodule